// File: doc/BRIEF.md
# Double-Key Register Write Protection

This block protects a set of memory-control and system-configuration registers from stray writes issued by a program that has lost control of its flow. It watches a simple peripheral register bus (address, write data, write strobe) and forwards a gated write strobe to the downstream register file. Writes to any address in a parameterised protected list are suppressed while protection is on. Each suppressed write raises a single-cycle interrupt request, so that a handler can take over.

Protection changes only after an ordered pair of bus writes to two key registers. The pair 0x5A to the first key register followed by 0xA5 to the second key register turns protection on. The pair 0xA5 to the first key followed by 0x5A to the second turns it off. A status register, read combinationally at its own address, reports the current state. The key registers and the status register are never blocked, so software can always release protection.

Top module: `reg_write_guard`

## Requirements
- R1: After reset, protection is off, `irq_o` is low and a read of the status address (default 0xE0) returns 0.
- R2: A write of 0x5A to key register 1 (default 0xE1), followed by the next bus write being 0xA5 to key register 2 (default 0xE2), turns protection on from the cycle after the second write.
- R3: A write of 0xA5 to key register 1, followed by the next bus write being 0x5A to key register 2, turns protection off from the cycle after the second write.
- R4: Any other bus write between the two key writes, or a wrong value at either key, aborts the sequence and leaves protection unchanged. Cycles with no write do not abort it. A valid first-key write that aborts a sequence starts a new one.
- R5: While protection is on, a write to an address in the protected list (default 0x10, 0x11, 0x20, 0xE2) is blocked: `wr_en_o` stays low in that cycle.
- R6: `irq_o` is high for exactly the cycle after each blocked write. Back-to-back blocked writes give back-to-back pulses.
- R7: While protection is off, and for addresses outside the protected list at any time, `wr_en_o` equals `we_i`.
- R8: Writes to the two key addresses and to the status address are never blocked, even when one of them is in the protected list.
- R9: `rdata_o` holds the protection state in bit 0 (1 = on) and zeros above it when `addr_i` equals the status address. It is 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | AW | Register bus address |
| wdata_i | input | DW | Register bus write data |
| we_i | input | 1 | Register bus write strobe |
| rdata_o | output | DW | Status read data for the addressed register |
| wr_en_o | output | 1 | Gated write strobe to the guarded register file |
| irq_o | output | 1 | Violation interrupt, one pulse per blocked write |

## Verification
The bench breaks key sequences in three ways: with an unrelated write between the two key writes, with a wrong value at the second key, and with a valid first-key write that restarts the sequence. It also checks that idle cycles between the two key writes are tolerated. A detector that ignored intervening writes would flip the state, and one that reset on idle cycles would refuse to release protection. A key address is placed in the protected list, which catches a design whose exemption is missing: that design could never be unlocked. Back-to-back blocked writes expose an interrupt that is stretched or merged instead of pulsed once per violation.

// File: rtl/rwg_pkg.sv
package rwg_pkg;
  localparam logic [7:0] KEY_A = 8'h5A;
  localparam logic [7:0] KEY_B = 8'hA5;

  typedef enum logic [1:0] {
    ARM_IDLE = 2'd0,
    ARM_SET  = 2'd1,
    ARM_CLR  = 2'd2
  } arm_e;
endpackage

// File: rtl/rwg_addr_match.sv
module rwg_addr_match #(
  parameter int unsigned AW    = 8,
  parameter int unsigned NPROT = 4,
  parameter logic [NPROT-1:0][AW-1:0] PROT_ADDRS = '0
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o
);
  logic [NPROT-1:0] hit_vec;

  for (genvar g = 0; g < NPROT; g++) begin : g_cmp
    assign hit_vec[g] = (addr_i == PROT_ADDRS[g]);
  end

  assign hit_o = |hit_vec;
endmodule

// File: rtl/rwg_key_fsm.sv
module rwg_key_fsm
  import rwg_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] KEY1_ADDR = '0,
  parameter logic [AW-1:0] KEY2_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          protect_o
);
  localparam logic [DW-1:0] KA = DW'(KEY_A);
  localparam logic [DW-1:0] KB = DW'(KEY_B);

  arm_e arm_q, arm_d;
  logic prot_q, prot_d;

  always_comb begin
    arm_d  = arm_q;
    prot_d = prot_q;
    if (we_i) begin
      // every write ends the pending sequence; a valid first key re-arms
      arm_d = ARM_IDLE;
      if (addr_i == KEY1_ADDR) begin
        if (wdata_i == KA)      arm_d = ARM_SET;
        else if (wdata_i == KB) arm_d = ARM_CLR;
      end
      if (addr_i == KEY2_ADDR) begin
        if (arm_q == ARM_SET && wdata_i == KB) prot_d = 1'b1;
        if (arm_q == ARM_CLR && wdata_i == KA) prot_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= ARM_IDLE;
      prot_q <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      prot_q <= prot_d;
    end
  end

  assign protect_o = prot_q;
endmodule

// File: rtl/rwg_gate.sv
module rwg_gate #(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] KEY1_ADDR   = '0,
  parameter logic [AW-1:0] KEY2_ADDR   = '0,
  parameter logic [AW-1:0] STATUS_ADDR = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          protect_i,
  input  logic          hit_i,
  output logic          wr_en_o,
  output logic          irq_o
);
  logic exempt, block;
  logic irq_q;

  assign exempt  = (addr_i == KEY1_ADDR) || (addr_i == KEY2_ADDR) ||
                   (addr_i == STATUS_ADDR);
  assign block   = we_i && protect_i && hit_i && !exempt;
  assign wr_en_o = we_i && !block;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= block;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/reg_write_guard.sv
module reg_write_guard #(
  parameter int unsigned AW    = 8,
  parameter int unsigned DW    = 8,
  parameter int unsigned NPROT = 4,
  parameter logic [NPROT-1:0][AW-1:0] PROT_ADDRS = {8'hE2, 8'h20, 8'h11, 8'h10},
  parameter logic [AW-1:0] STATUS_ADDR = 8'hE0,
  parameter logic [AW-1:0] KEY1_ADDR   = 8'hE1,
  parameter logic [AW-1:0] KEY2_ADDR   = 8'hE2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] rdata_o,
  output logic          wr_en_o,
  output logic          irq_o
);
  logic protect_q;
  logic prot_hit;

  rwg_key_fsm #(
    .AW(AW), .DW(DW), .KEY1_ADDR(KEY1_ADDR), .KEY2_ADDR(KEY2_ADDR)
  ) u_key (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .protect_o(protect_q)
  );

  rwg_addr_match #(
    .AW(AW), .NPROT(NPROT), .PROT_ADDRS(PROT_ADDRS)
  ) u_match (
    .addr_i(addr_i), .hit_o(prot_hit)
  );

  rwg_gate #(
    .AW(AW), .KEY1_ADDR(KEY1_ADDR), .KEY2_ADDR(KEY2_ADDR), .STATUS_ADDR(STATUS_ADDR)
  ) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .protect_i(protect_q), .hit_i(prot_hit), .wr_en_o(wr_en_o), .irq_o(irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == STATUS_ADDR) rdata_o[0] = protect_q;
  end
endmodule

// File: rtl/reg_write_guard_chk.sv
module reg_write_guard_chk #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] STATUS_ADDR = '0,
  parameter logic [AW-1:0] KEY1_ADDR   = '0,
  parameter logic [AW-1:0] KEY2_ADDR   = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          we_i,
  input logic [DW-1:0] rdata_o,
  input logic          wr_en_o,
  input logic          irq_o,
  input logic          protect_q
);
  // R6
  irq_after_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wr_en_o) |=> irq_o);
  // R6
  irq_only_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && !wr_en_o) |=> !irq_o);
  // R7
  pass_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !protect_q) |-> wr_en_o);
  // R8
  exempt_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == KEY1_ADDR || addr_i == KEY2_ADDR || addr_i == STATUS_ADDR))
      |-> wr_en_o);
  // R2
  rise_by_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(protect_q) |-> $past(we_i && addr_i == KEY2_ADDR && wdata_i == DW'(8'hA5)));
  // R3
  fall_by_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(protect_q) |-> $past(we_i && addr_i == KEY2_ADDR && wdata_i == DW'(8'h5A)));
  // R9
  status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == STATUS_ADDR) |-> (rdata_o == DW'(protect_q)));
endmodule

bind reg_write_guard reg_write_guard_chk #(
  .AW(AW), .DW(DW), .STATUS_ADDR(STATUS_ADDR), .KEY1_ADDR(KEY1_ADDR), .KEY2_ADDR(KEY2_ADDR)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
  .rdata_o(rdata_o), .wr_en_o(wr_en_o), .irq_o(irq_o), .protect_q(protect_q)
);

// File: tb/reg_write_guard_tb_top.sv
module reg_write_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic       wr_en, irq;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  reg_write_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .wr_en_o(wr_en), .irq_o(irq)
  );

  // reference model
  logic m_prot = 1'b0;
  int   m_arm  = 0;   // 0 idle, 1 armed for on, 2 armed for off
  logic exp_q[$];
  string tag_q[$];
  logic pend_irq = 1'b0;
  string pend_tag = "R6";

  function automatic logic listed(logic [7:0] a);
    return a == 8'h10 || a == 8'h11 || a == 8'h20 || a == 8'hE2;
  endfunction

  function automatic logic exempt(logic [7:0] a);
    return a == 8'hE0 || a == 8'hE1 || a == 8'hE2;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, string tag);
    logic blk;
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    blk = m_prot && listed(a) && !exempt(a);
    exp_q.push_back(!blk);
    tag_q.push_back(tag);
    if (a == 8'hE2 && m_arm == 1 && d == 8'hA5) m_prot = 1'b1;
    if (a == 8'hE2 && m_arm == 2 && d == 8'h5A) m_prot = 1'b0;
    if (a == 8'hE1 && d == 8'h5A)      m_arm = 1;
    else if (a == 8'hE1 && d == 8'hA5) m_arm = 2;
    else                               m_arm = 0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    @(negedge clk);
    addr = a; we = 1'b0;
    #3;
    check(tag, rdata, (a == 8'hE0) ? {7'b0, m_prot} : 8'h00);
  endtask

  task automatic idle();
    @(negedge clk);
    we = 1'b0;
  endtask

  // monitor: gated strobe in the write cycle, interrupt one cycle later
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n) begin
        check(pend_tag, {7'b0, irq}, {7'b0, pend_irq});
        pend_irq = 1'b0;
        pend_tag = "R6";
        if (we) begin
          logic e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {7'b0, wr_en}, {7'b0, e});
          pend_irq = !e;
          pend_tag = {t, "/R6"};
        end
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(8'hE0, "R1");
    check("R1", {7'b0, irq}, 8'h00);
    wr(8'h10, 8'h33, "R7");
    wr(8'hE2, 8'h44, "R7");
    idle();
    // turn on
    wr(8'hE1, 8'h5A, "R2");
    wr(8'hE2, 8'hA5, "R2");
    rd(8'hE0, "R2");
    rd(8'h10, "R9");
    // blocked writes, back-to-back
    wr(8'h10, 8'h01, "R5");
    wr(8'h11, 8'h02, "R5");
    wr(8'h20, 8'h03, "R5");
    idle();
    wr(8'h40, 8'h04, "R7");
    wr(8'hE2, 8'h00, "R8");
    wr(8'hE0, 8'h00, "R8");
    wr(8'hE1, 8'h00, "R8");
    idle();
    // aborted sequences
    wr(8'hE1, 8'hA5, "R4");
    wr(8'h40, 8'h00, "R4");
    wr(8'hE2, 8'h5A, "R4");
    rd(8'hE0, "R4");
    wr(8'hE1, 8'hA5, "R4");
    wr(8'hE2, 8'h5B, "R4");
    rd(8'hE0, "R4");
    wr(8'hE1, 8'hA5, "R4");
    wr(8'h10, 8'h00, "R4");
    wr(8'hE2, 8'h5A, "R4");
    rd(8'hE0, "R4");
    // idle cycles between keys keep the sequence
    wr(8'hE1, 8'hA5, "R3");
    idle();
    idle();
    wr(8'hE2, 8'h5A, "R3");
    rd(8'hE0, "R3");
    wr(8'h10, 8'h55, "R7");
    idle();
    // restart via a new first key, then clean clear
    wr(8'hE1, 8'hA5, "R4");
    wr(8'hE1, 8'h5A, "R4");
    wr(8'hE2, 8'hA5, "R4");
    rd(8'hE0, "R4");
    wr(8'hE1, 8'hA5, "R3");
    wr(8'hE2, 8'h5A, "R3");
    rd(8'hE0, "R3");
    wr(8'h20, 8'h66, "R7");
    rd(8'hE0, "R9");
    idle();
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule